// File: doc/BRIEF.md
# External Bus Idle-Gap Sequencer

This block runs access cycles on an external memory bus. The bus is divided into separately chip-selected address areas. Each request carries an area number, a direction, an address and a length flag. The length flag selects a cycle of two states (T1, T2) or three states (T1, T2, T3). From each request the block produces the active-low chip selects, the active-low read and write strobes, the address and the write-data output enable.

When a read cycle is followed directly by a cycle to a different area, the block can place one idle bus state (TI) between the two cycles. This gap serves two purposes:

- It keeps the slow-falling read strobe of the first cycle clear of the next area's chip select.
- It keeps a data bus that is still floating off after a read from meeting the write driver of the next cycle.

Each of the two cases has its own enable bit. Both bits are set at reset. When an enable bit is cleared, the next cycle begins with no gap. A ready/valid handshake lets requests arrive back to back. The block takes a new request only in the final state of a cycle or while the bus is idle.

Top module: `bus_idle_gap`

## Requirements
- R1: While reset is held and right after it, every chip select, rd_n and wr_n is high, dout_en is low, req_ready is high, and both gap enables read as set.
- R2: Each accepted request makes exactly one bus cycle of 2 states (req_long=0) or 3 states (req_long=1). The cycle starts in the clock after acceptance, or after the single gap state when a gap applies.
- R3: In every state of a cycle, only cs_n[req_area] is low (binary area number, bit i selects area i) and addr equals the request address.
- R4: For a read (req_write=0), rd_n is low from T1 through the final state and high at all other times.
- R5: For a write (req_write=1), wr_n is low and dout_en is high from T2 through the final state, and never in T1, in a gap state or in idle.
- R6: With the read-to-read enable set, a read followed directly by a read to a different area gets exactly one gap state. In that state all chip selects, rd_n and wr_n are high and dout_en is low.
- R7: With the read-to-write enable set, a read followed directly by a write to a different area gets exactly one gap state with all outputs inactive.
- R8: When the enable bit for the case at hand is clear, T1 of the next cycle follows the final state of the read directly.
- R9: A cycle to the same area as the cycle before it never gets a gap, and neither does a cycle that follows a write.
- R10: req_ready is high only in idle or in a cycle's final state. A request with req_valid and req_ready high at a rising edge is accepted at that edge.
- R11: A rising edge with cfg_load high loads cfg_gap_rr (read-to-read enable) and cfg_gap_rw (read-to-write enable). These values govern requests accepted at later edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load strobe for the two gap enables |
| cfg_gap_rr | input | 1 | Read-to-read, different-area gap enable |
| cfg_gap_rw | input | 1 | Read-to-write, different-area gap enable |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_area | input | AREA_W | Target area number |
| req_write | input | 1 | 1 for write, 0 for read |
| req_long | input | 1 | 1 for a three-state cycle |
| req_addr | input | ADDR_W | Access address |
| cs_n | output | NUM_AREAS | Active-low chip selects |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| dout_en | output | 1 | Write-data output enable |
| addr | output | ADDR_W | Bus address |

## Verification
All bus outputs decode directly from the state, area and direction registers. A wrong state, a stale area or a lost direction bit therefore shows at the pins in the same clock. It appears as a chip select on the wrong line, a strobe that is one state early or late, or a gap that is missing or added. A wrong gap decision changes the position of every later cycle by one state, so it also makes req_ready disagree at the following handshake. For these reasons, every output and req_ready is compared against an independent per-cycle model on every clock.

// File: rtl/bus_idle_gap.sv
module bus_idle_gap #(
  parameter int NUM_AREAS = 8,
  parameter int ADDR_W = 16,
  localparam int AREA_W = (NUM_AREAS > 1) ? $clog2(NUM_AREAS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_load,
  input  logic                 cfg_gap_rr,
  input  logic                 cfg_gap_rw,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [AREA_W-1:0]    req_area,
  input  logic                 req_write,
  input  logic                 req_long,
  input  logic [ADDR_W-1:0]    req_addr,
  output logic [NUM_AREAS-1:0] cs_n,
  output logic                 rd_n,
  output logic                 wr_n,
  output logic                 dout_en,
  output logic [ADDR_W-1:0]    addr
);

  typedef enum logic [2:0] {S_IDLE, S_T1, S_T2, S_T3, S_TI} st_t;

  st_t st, nxt;
  logic [AREA_W-1:0] area_q;
  logic [ADDR_W-1:0] addr_q;
  logic wr_q, long_q, gap_rr_q, gap_rw_q;

  logic last, take, need_gap, act, dphase;

  assign last      = (st == S_T2 && !long_q) || st == S_T3;
  assign req_ready = (st == S_IDLE) || last;
  assign take      = req_valid && req_ready;
  assign need_gap  = last && !wr_q && (req_area != area_q) &&
                     (req_write ? gap_rw_q : gap_rr_q);

  always_comb begin
    nxt = st;
    if (take) nxt = need_gap ? S_TI : S_T1;
    else begin
      case (st)
        S_IDLE:  nxt = S_IDLE;
        S_T1:    nxt = S_T2;
        S_T2:    nxt = long_q ? S_T3 : S_IDLE;
        S_T3:    nxt = S_IDLE;
        S_TI:    nxt = S_T1;
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      area_q   <= '0;
      addr_q   <= '0;
      wr_q     <= 1'b0;
      long_q   <= 1'b0;
      gap_rr_q <= 1'b1;
      gap_rw_q <= 1'b1;
    end else begin
      st <= nxt;
      if (take) begin
        area_q <= req_area;
        addr_q <= req_addr;
        wr_q   <= req_write;
        long_q <= req_long;
      end
      if (cfg_load) begin
        gap_rr_q <= cfg_gap_rr;
        gap_rw_q <= cfg_gap_rw;
      end
    end
  end

  assign act    = (st == S_T1) || (st == S_T2) || (st == S_T3);
  assign dphase = (st == S_T2) || (st == S_T3);

  for (genvar i = 0; i < NUM_AREAS; i++) begin : g_cs
    assign cs_n[i] = !(act && area_q == AREA_W'(i));
  end

  assign rd_n    = !(act && !wr_q);
  assign wr_n    = !(dphase && wr_q);
  assign dout_en = dphase && wr_q;
  assign addr    = addr_q;

  p_gap_one_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_TI |=> st == S_T1);

  p_rr_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!rd_n) && !rd_n && $past(gap_rr_q)) |-> cs_n == $past(cs_n));

  p_oe_not_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_en) |-> $past(st) == S_T1);

  p_accept_starts_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (st == S_T1 || st == S_TI));

endmodule

// File: tb/bus_idle_gap_test.sv
module bus_idle_gap_test;
  localparam int NA = 8;
  localparam int AW = 3;
  localparam int DW = 16;

  logic clk = 0, rst_n = 0;
  logic cfg_load = 0, cfg_gap_rr = 0, cfg_gap_rw = 0;
  logic req_valid = 0, req_write = 0, req_long = 0;
  logic [AW-1:0] req_area = '0;
  logic [DW-1:0] req_addr = '0;
  logic req_ready, rd_n, wr_n, dout_en;
  logic [NA-1:0] cs_n;
  logic [DW-1:0] addr;

  bus_idle_gap #(.NUM_AREAS(NA), .ADDR_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_gap_rr(cfg_gap_rr),
    .cfg_gap_rw(cfg_gap_rw), .req_valid(req_valid), .req_ready(req_ready),
    .req_area(req_area), .req_write(req_write), .req_long(req_long),
    .req_addr(req_addr), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .dout_en(dout_en), .addr(addr));

  always #2 clk = ~clk;

  typedef struct packed {
    logic act; logic gap; logic [AW-1:0] area; logic rd; logic wr; logic oe; logic [DW-1:0] a;
  } ent_t;

  ent_t q[$];
  ent_t cur;
  bit en_rr = 1, en_rw = 1;
  int checks = 0, errors = 0, gaps_seen = 0;

  task automatic chk(bit ok, string tag, longint act_v, longint exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act_v, exp_v, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); cur = '0; en_rr = 1; en_rw = 1;
    end else begin
      if (req_valid && q.size() == 0) begin
        ent_t e;
        bit g;
        g = cur.act && cur.rd && cur.area != req_area && (req_write ? en_rw : en_rr);
        if (g) begin e = '0; e.gap = 1; q.push_back(e); end
        e = '0; e.act = 1; e.area = req_area; e.rd = !req_write; e.a = req_addr;
        q.push_back(e);
        e.wr = req_write; e.oe = req_write;
        q.push_back(e);
        if (req_long) q.push_back(e);
      end
      if (cfg_load) begin en_rr = cfg_gap_rr; en_rw = cfg_gap_rw; end
      cur = (q.size() != 0) ? q.pop_front() : '0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic [NA-1:0] ecs;
      string tg;
      ecs = '1;
      if (cur.act) ecs[cur.area] = 1'b0;
      if (cur.gap) gaps_seen++;
      tg = cur.gap ? "R6/R7 gap cs" : "R3/R8/R9 cs";
      chk(cs_n == ecs, tg, cs_n, ecs);
      chk(rd_n == !(cur.act && cur.rd), cur.gap ? "R6/R7 gap rd_n" : "R4 rd_n", rd_n, !(cur.act && cur.rd));
      chk(wr_n == !cur.wr, "R5 wr_n", wr_n, !cur.wr);
      chk(dout_en == cur.oe, "R5 dout_en", dout_en, cur.oe);
      chk(req_ready == (q.size() == 0), "R10 R2 req_ready", req_ready, q.size() == 0);
      if (cur.act) chk(addr == cur.a, "R3 addr", addr, cur.a);
    end
  end

  task automatic send(int area, bit w, bit lng, int a);
    bit r;
    req_valid = 1; req_area = AW'(area); req_write = w; req_long = lng; req_addr = DW'(a);
    do begin
      r = req_ready;
      @(negedge clk);
    end while (!r);
  endtask

  task automatic rest(int n);
    req_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(bit rr, bit rw);
    cfg_gap_rr = rr; cfg_gap_rw = rw; cfg_load = 1;
    @(negedge clk);
    cfg_load = 0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk(cs_n == '1, "R1 cs_n in reset", cs_n, '1);
    chk(rd_n && wr_n, "R1 strobes in reset", {rd_n, wr_n}, 2'b11);
    chk(!dout_en, "R1 dout_en in reset", dout_en, 0);
    chk(req_ready, "R1 req_ready in reset", req_ready, 1);
    rst_n = 1;
    @(negedge clk);
    // R1 R6: default enables give a gap on read to read, other area
    send(0, 0, 0, 'h100); send(1, 0, 0, 'h200); rest(4);
    chk(gaps_seen == 1, "R1 R6 default gap count", gaps_seen, 1);
    // R7
    send(1, 0, 1, 'h210); send(2, 1, 0, 'h300); rest(4);
    chk(gaps_seen == 2, "R7 gap count", gaps_seen, 2);
    // R9: same area, and after writes
    send(2, 0, 0, 'h301); send(2, 0, 1, 'h302); send(2, 1, 0, 'h303);
    send(3, 1, 1, 'h400); send(4, 0, 0, 'h500); send(4, 0, 1, 'h501); rest(4);
    chk(gaps_seen == 2, "R9 no gap count", gaps_seen, 2);
    // R11 R8: read-to-read gap off, read-to-write on
    cfg(0, 1);
    send(0, 0, 0, 'h10); send(1, 0, 0, 'h20); send(2, 1, 0, 'h30); rest(4);
    chk(gaps_seen == 3, "R8 R11 rr off", gaps_seen, 3);
    cfg(1, 0);
    send(5, 0, 1, 'h50); send(6, 1, 1, 'h60); send(6, 0, 0, 'h61); send(7, 0, 0, 'h70); rest(4);
    chk(gaps_seen == 4, "R8 R11 rw off", gaps_seen, 4);
    cfg(0, 0);
    send(0, 0, 0, 'h1); send(1, 0, 1, 'h2); send(2, 1, 0, 'h3); rest(4);
    chk(gaps_seen == 4, "R8 both off", gaps_seen, 4);
    // R2 R10: random mix with varied enables and pauses
    for (int blk = 0; blk < 20; blk++) begin
      cfg(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      for (int k = 0; k < 30; k++) begin
        send($urandom_range(0, NA - 1), 1'($urandom_range(0, 1)),
             1'($urandom_range(0, 1)), $urandom_range(0, 65535));
        if ($urandom_range(0, 5) == 0) rest($urandom_range(1, 3));
      end
      rest(4);
    end
    finish_run();
  end
endmodule